// File: doc/BRIEF.md
# Background-Reload Down-Counter Timer

This block is a single down-counting timer channel. Software reaches it through a plain strobe-based register port: an address, a write strobe with write data, and a read strobe with read data. The counter can be loaded in two ways. A direct load restarts the count from the written value at once. A background load changes only the value used at the next reload, and the count in progress carries on.

The channel runs in one of two modes. In periodic mode it reloads each time it reaches zero. In one-shot mode it stops at zero. Reaching zero sets a raw status flag, and software clears that flag by writing a one to it. A level interrupt output is the raw flag gated by an interrupt enable bit. Widths are parameters, and a parameter selects whether read data is combinational or registered.

Register word offsets are 0x00 current count (read-only), 0x04 load, 0x08 background load, 0x0C control, 0x10 raw status and 0x14 masked status (read-only).

Top module: `bgload_timer`

## Requirements
- R1: A write to offset 0x04 puts the written value into both the counter and the stored reload value at that clock edge, whether the timer is enabled or not. It takes priority over a decrement in the same cycle. Reading 0x04 returns the stored reload value.
- R2: A write to offset 0x08 changes only the stored reload value. The counter keeps its normal progression in that cycle, and the next periodic reload uses the new value.
- R3: With control bit 0 (enable) at 1, the counter drops by one on each clock while it is non-zero. With bit 0 at 0, the counter keeps its value.
- R4: In periodic mode (control bit 1 = 0), an enabled counter at zero is reloaded from the stored reload value on the next clock.
- R5: In one-shot mode (control bit 1 = 1), an enabled counter stays at zero until it is loaded again through 0x04.
- R6: Raw status (bit 0 of 0x10) becomes 1 on the clock edge at which an enabled counter steps from 1 to 0. Writing 0x10 with bit 0 = 1 clears it. Writing bit 0 = 0 leaves it unchanged.
- R7: When the counter steps to zero in the same cycle as a clearing write to 0x10, raw status ends up at 1.
- R8: The irq output and bit 0 of 0x14 both equal raw status AND control bit 2 (interrupt enable).
- R9: Control at 0x0C holds enable in bit 0, mode in bit 1 and interrupt enable in bit 2. Bits above bit 2 read as zero whatever was written.
- R10: Writes to offset 0x00 and offset 0x14 change no state.
- R11: After reset, every register reads zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| rd_en | input | 1 | Read strobe; rdata is zero when low |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data |
| irq | output | 1 | Level interrupt, equal to masked status |

## Verification
Four corner cases get the most attention: a background load in the middle of a count, a direct load while the counter is running, a clearing write that lands on the same edge the counter reaches zero, and a one-shot counter sitting at zero for many cycles. Each one exposes a specific fault. A design that treats a background write as a direct load makes the count jump instead of continuing. A design that lets the clear win loses an interrupt. A one-shot design that reloads keeps firing. A design that counts a 0-write as a clear, or lets writes to read-only offsets reach the counter, corrupts state that should not move. The reload checks read the count on the exact cycle after zero, so an off-by-one period shows up at once.

// File: rtl/bgload_timer_pkg.sv
`timescale 1ns/1ps
package bgload_timer_pkg;
   localparam int unsigned OFS_VALUE  = 'h00;
   localparam int unsigned OFS_LOAD   = 'h04;
   localparam int unsigned OFS_BGLOAD = 'h08;
   localparam int unsigned OFS_CTRL   = 'h0C;
   localparam int unsigned OFS_RAW    = 'h10;
   localparam int unsigned OFS_MASKED = 'h14;
   localparam int unsigned CTRL_BITS  = 3;

   typedef struct packed {
      logic ie;
      logic one_shot;
      logic en;
   } tmr_ctrl_t;
endpackage

// File: rtl/bgload_timer_regs.sv
`timescale 1ns/1ps
module bgload_timer_regs
   import bgload_timer_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned CNT_W     = 32,
   parameter bit          RDATA_REG = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [CTRL_BITS-1:0] wbits,
   input  logic [CNT_W-1:0]     cnt,
   input  logic [CNT_W-1:0]     load_val,
   input  logic                 raw,
   input  logic                 irq,
   output logic                 load_wr,
   output logic                 bg_wr,
   output logic                 clr_wr,
   output tmr_ctrl_t            ctrl,
   output logic [DATA_W-1:0]    rdata
);
   logic              ctrl_wr;
   logic [DATA_W-1:0] rd_mux;

   // write decode: offsets 0x00 and 0x14 have no decode and so no effect
   always_comb begin
      load_wr = wr_en && (addr == ADDR_W'(OFS_LOAD));
      bg_wr   = wr_en && (addr == ADDR_W'(OFS_BGLOAD));
      ctrl_wr = wr_en && (addr == ADDR_W'(OFS_CTRL));
      clr_wr  = wr_en && (addr == ADDR_W'(OFS_RAW)) && wbits[0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl <= '0;
      else if (ctrl_wr) ctrl <= tmr_ctrl_t'(wbits);
   end

   always_comb begin
      rd_mux = '0;
      case (addr)
         ADDR_W'(OFS_VALUE):  rd_mux = DATA_W'(cnt);
         ADDR_W'(OFS_LOAD),
         ADDR_W'(OFS_BGLOAD): rd_mux = DATA_W'(load_val);
         ADDR_W'(OFS_CTRL):   rd_mux[CTRL_BITS-1:0] = ctrl;
         ADDR_W'(OFS_RAW):    rd_mux[0] = raw;
         ADDR_W'(OFS_MASKED): rd_mux[0] = irq;
         default:             rd_mux = '0;
      endcase
   end

   generate
      if (RDATA_REG) begin : g_rd_ff
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata <= '0;
            else        rdata <= rd_en ? rd_mux : '0;
         end
      end else begin : g_rd_comb
         assign rdata = rd_en ? rd_mux : '0;
      end
   endgenerate
endmodule

// File: rtl/bgload_timer_count.sv
`timescale 1ns/1ps
module bgload_timer_count #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             one_shot,
   input  logic             load_wr,
   input  logic             bg_wr,
   input  logic [CNT_W-1:0] wval,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] load_val,
   output logic             hit
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   // zero is reached on the step from one; a direct load pre-empts it
   assign hit = en && !load_wr && (cnt == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         load_val <= '0;
      end else if (load_wr) begin
         cnt      <= wval;
         load_val <= wval;
      end else begin
         if (bg_wr) load_val <= wval;
         if (en) begin
            if (cnt != '0)     cnt <= cnt - ONE;
            else if (!one_shot) cnt <= load_val;
         end
      end
   end
endmodule

// File: rtl/bgload_timer_irq.sv
`timescale 1ns/1ps
module bgload_timer_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic hit,
   input  logic clr,
   input  logic ie,
   output logic raw,
   output logic irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   raw <= 1'b0;
      else if (hit) raw <= 1'b1;
      else if (clr) raw <= 1'b0;
   end

   assign irq = raw & ie;
endmodule

// File: rtl/bgload_timer.sv
`timescale 1ns/1ps
module bgload_timer
   import bgload_timer_pkg::*;
#(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned CNT_W     = 32,
   parameter bit          RDATA_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   localparam int unsigned MIN_ADDR_W = $clog2(OFS_MASKED + 1);

   generate
      if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("bgload_timer: CNT_W must be in 2..DATA_W");
      end
      if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr_w
         $error("bgload_timer: ADDR_W too narrow for the register map");
      end
   endgenerate

   tmr_ctrl_t        ctrl_q;
   logic             load_wr, bg_wr, clr_wr, hit, raw_q;
   logic [CNT_W-1:0] cnt_q, load_q;

   bgload_timer_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RDATA_REG(RDATA_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wbits(wdata[CTRL_BITS-1:0]), .cnt(cnt_q), .load_val(load_q),
      .raw(raw_q), .irq(irq), .load_wr(load_wr), .bg_wr(bg_wr),
      .clr_wr(clr_wr), .ctrl(ctrl_q), .rdata(rdata)
   );

   bgload_timer_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n), .en(ctrl_q.en), .one_shot(ctrl_q.one_shot),
      .load_wr(load_wr), .bg_wr(bg_wr), .wval(wdata[CNT_W-1:0]),
      .cnt(cnt_q), .load_val(load_q), .hit(hit)
   );

   bgload_timer_irq u_irq (
      .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr_wr), .ie(ctrl_q.ie),
      .raw(raw_q), .irq(irq)
   );
endmodule

// File: rtl/bgload_timer_chk.sv
`timescale 1ns/1ps
module bgload_timer_chk
   import bgload_timer_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned CNT_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              irq,
   input logic [CNT_W-1:0]  cnt_q,
   input logic [CNT_W-1:0]  load_q,
   input logic              en,
   input logic              one_shot,
   input logic              ie,
   input logic              raw_q
);
   logic ld, bg;
   assign ld = wr_en && (addr == ADDR_W'(OFS_LOAD));
   assign bg = wr_en && (addr == ADDR_W'(OFS_BGLOAD));

   // R1
   direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld |=> (cnt_q == $past(wdata[CNT_W-1:0])));
   // R3
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !ld && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));
   // R3
   hold_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !ld) |=> $stable(cnt_q));
   // R2
   bg_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bg && !en) |=> $stable(cnt_q));
   // R4
   periodic_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !one_shot && !ld && cnt_q == '0) |=> (cnt_q == $past(load_q)));
   // R5
   oneshot_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && one_shot && !ld && cnt_q == '0) |=> (cnt_q == '0));
   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !ld && cnt_q == CNT_W'(1)) |=> raw_q);
   // R8
   irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie || !raw_q) |-> !irq);
endmodule

bind bgload_timer bgload_timer_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .irq(irq), .cnt_q(cnt_q), .load_q(load_q), .en(ctrl_q.en),
   .one_shot(ctrl_q.one_shot), .ie(ctrl_q.ie), .raw_q(raw_q)
);

// File: tb/test_bgload_timer.sv
`timescale 1ns/1ps
module test_bgload_timer;
   localparam real HALF = 4.0;
   localparam logic [7:0] A_VAL = 8'h00, A_LD = 8'h04, A_BG = 8'h08,
                          A_CTL = 8'h0C, A_RAW = 8'h10, A_MSK = 8'h14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          n_run = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #(HALF) clk = ~clk;

   bgload_timer i_bgload_timer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   // called at the falling edge; returns at the next falling edge
   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(posedge clk);
      #(HALF);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      rd_en = 1'b1; addr = a;
      #0.2;
      d = rdata;
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic t_reset();
      rd_chk("R11 value", A_VAL, 0);
      rd_chk("R11 load", A_LD, 0);
      rd_chk("R11 ctrl", A_CTL, 0);
      rd_chk("R11 raw", A_RAW, 0);
      idle(1);
      rd_chk("R11 masked", A_MSK, 0);
      chk("R11 irq", {31'd0, irq}, 0);
   endtask

   task automatic t_ctrl_layout();
      wr(A_CTL, 32'hFFFF_FFF8);
      rd_chk("R9 reserved bits", A_CTL, 0);
      wr(A_CTL, 32'h0000_0006);
      rd_chk("R9 ie+mode", A_CTL, 6);
      wr(A_CTL, 0);
   endtask

   task automatic t_direct_hold();
      wr(A_LD, 100);
      rd_chk("R1 count loaded", A_VAL, 100);
      rd_chk("R1 load readback", A_LD, 100);
      idle(5);
      rd_chk("R3 disabled hold", A_VAL, 100);
   endtask

   task automatic t_decrement();
      wr(A_CTL, 1);
      rd_chk("R3 no step before enable", A_VAL, 100);
      idle(4);
      rd_chk("R3 four steps", A_VAL, 96);
   endtask

   task automatic t_load_running();
      wr(A_LD, 50);
      rd_chk("R1 load while running", A_VAL, 50);
      idle(2);
      rd_chk("R1 continues from load", A_VAL, 48);
   endtask

   task automatic t_periodic();
      wr(A_RAW, 1);
      wr(A_LD, 3);
      rd_chk("R1 count 3", A_VAL, 3);
      idle(2);
      rd_chk("R3 count 1", A_VAL, 1);
      rd_chk("R6 raw still 0", A_RAW, 0);
      idle(1);
      rd_chk("R6 at zero", A_VAL, 0);
      rd_chk("R6 raw set", A_RAW, 1);
      idle(1);
      rd_chk("R4 reload", A_VAL, 3);
   endtask

   task automatic t_background();
      wr(A_BG, 9);
      rd_chk("R2 count undisturbed", A_VAL, 2);
      rd_chk("R2 stored value", A_LD, 9);
      idle(2);
      rd_chk("R2 reaches zero", A_VAL, 0);
      idle(1);
      rd_chk("R2 reload from new value", A_VAL, 9);
   endtask

   task automatic t_w1c();
      wr(A_RAW, 0);
      rd_chk("R6 write 0 no effect", A_RAW, 1);
      wr(A_RAW, 1);
      rd_chk("R6 write 1 clears", A_RAW, 0);
   endtask

   task automatic t_irq();
      wr(A_CTL, 1);
      wr(A_LD, 1);
      idle(1);
      rd_chk("R6 raw from 1 to 0", A_RAW, 1);
      chk("R8 irq masked off", {31'd0, irq}, 0);
      rd_chk("R8 masked reg off", A_MSK, 0);
      wr(A_CTL, 4);
      chk("R8 irq on", {31'd0, irq}, 1);
      rd_chk("R8 masked reg on", A_MSK, 1);
      wr(A_RAW, 1);
      chk("R8 irq after clear", {31'd0, irq}, 0);
   endtask

   task automatic t_set_wins();
      wr(A_LD, 2);
      wr(A_CTL, 1);
      rd_chk("R3 enable edge no step", A_VAL, 2);
      idle(1);
      rd_chk("R7 count 1", A_VAL, 1);
      rd_chk("R7 raw clear before", A_RAW, 0);
      wr(A_RAW, 1);
      rd_chk("R7 set beats clear", A_RAW, 1);
      rd_chk("R7 count zero", A_VAL, 0);
   endtask

   task automatic t_oneshot();
      wr(A_RAW, 1);
      wr(A_CTL, 3);
      wr(A_LD, 4);
      idle(4);
      rd_chk("R5 reaches zero", A_VAL, 0);
      idle(6);
      rd_chk("R5 stays zero", A_VAL, 0);
      rd_chk("R5 raw set", A_RAW, 1);
      wr(A_LD, 2);
      rd_chk("R5 restart by load", A_VAL, 2);
      idle(1);
      rd_chk("R5 counting again", A_VAL, 1);
   endtask

   task automatic t_ignored();
      logic [31:0] v;
      wr(A_CTL, 0);
      rd(A_VAL, v);
      wr(A_VAL, 32'hDEAD_BEEF);
      rd_chk("R10 value write ignored", A_VAL, v);
      rd_chk("R10 load unchanged", A_LD, 2);
      wr(A_MSK, 32'h0000_0001);
      rd_chk("R10 masked write, raw kept", A_RAW, 1);
      rd_chk("R10 masked write, ctrl kept", A_CTL, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctrl_layout();
      t_direct_hold();
      t_decrement();
      t_load_running();
      t_periodic();
      t_background();
      t_w1c();
      t_irq();
      t_set_wins();
      t_oneshot();
      t_ignored();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog (all requirements) actual=timeout expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule